// File: doc/BRIEF.md
# Periodic Output Impedance Step Controller

This block keeps the 5-bit strength code of an output driver that has 32 binary-weighted steps. A free-running timer opens one evaluation every 64 clocks. At each evaluation the block reads a direction from an external comparator and moves an internal pending code one step up, one step down, or not at all. The pending code never wraps: it stops at 0 and at 31.

The pending code is copied to the applied driver code only when the bus enters high impedance. This happens on a write, on a deselect, or when the output enable goes high. As a result, the driver strength never changes while the block is actively driving. If several evaluations happen during one driving stretch, the next high-Z entry applies only the most recent pending value.

A power-up counter runs for 4096 clocks after reset. The calibrated flag is raised at the first high-Z entry after that count has expired. From then on the applied code is known to have settled.

Top module: `imp_step_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `drv_code` equals 16 (mid-scale), the pending code is 16 and `cal_done` is 0.
- R2: An evaluation happens on the 64th rising edge after reset is released and on every 64th edge after that. `cmp_dir` is sampled only on those edges.
- R3: At an evaluation, `cmp_dir` = 2'b01 raises the pending code by one and 2'b10 lowers it by one. Both 2'b00 and 2'b11 leave it unchanged.
- R4: The pending code saturates. A raise at 31 stays at 31, and a lower at 0 stays at 0.
- R5: A high-Z entry is a rising edge at which `out_hiz` is 1 and was 0 at the previous edge. `drv_code` changes only at an entry, and then takes the pending value held just before that edge. If an entry and an evaluation fall on the same edge, the entry applies the value from before the evaluation. A high `out_hiz` in the first edge after reset is not an entry.
- R6: While `out_hiz` stays high, evaluations do not reach `drv_code`. Their result is applied at the next fresh entry.
- R7: When several evaluations occur between two entries, only the pending value present at the second entry is applied.
- R8: `cal_done` stays 0 through entries that happen within the first 4096 edges after reset. It rises at the first entry after that point and then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmp_dir | input | 2 | Comparator direction: 01 raise, 10 lower, 00/11 hold |
| out_hiz | input | 1 | 1 while the output bus is in high impedance |
| drv_code | output | 5 | Applied driver strength code |
| cal_done | output | 1 | Power-up calibration complete |

## Verification
An evaluation's result reaches `drv_code` one edge after the next high-Z entry. Because of this, the bench waits for the evaluation edge (a multiple of 64 edges after reset, counted by the bench) and then raises `out_hiz` for one edge. It samples at the falling edge that follows the entry. Non-applied windows are sampled just after the evaluation edge, where `drv_code` must still show the earlier value. A dedicated case puts an entry on the 64th edge itself, so the applied value must predate that edge's step. The calibrated flag is sampled at the falling edge after the first entry beyond edge 4096, and also after an entry before it.

// File: rtl/imp_pkg.sv
package imp_pkg;

    // Comparator direction encoding as seen on the cmp_dir port.
    typedef enum logic [1:0] {
        DIR_HOLD = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10,
        DIR_IDLE = 2'b11
    } dir_e;

    // Evaluation event passed from the timer to the pending tracker.
    typedef struct packed {
        logic fire;
        dir_e dir;
    } eval_t;

    // One saturating step of the code toward the comparator's request.
    function automatic int step_sat(int cur, int max_code, dir_e d);
        int res;
        res = cur;
        case (d)
            DIR_UP:   res = (cur >= max_code) ? max_code : cur + 1;
            DIR_DOWN: res = (cur <= 0) ? 0 : cur - 1;
            default:  res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/imp_eval_timer.sv
module imp_eval_timer
    import imp_pkg::*;
#(
    parameter int EVAL_CYCLES = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  dir_e  dir_i,
    output eval_t ev_o
);
    localparam int CW = (EVAL_CYCLES > 2) ? $clog2(EVAL_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(EVAL_CYCLES - 1);
    localparam bit POW2 = ((EVAL_CYCLES & (EVAL_CYCLES - 1)) == 0);

    logic [CW-1:0] cnt;

    generate
        if (POW2) begin : g_wrap
            // Interval is a power of two: natural counter rollover.
            always_ff @(posedge clk) begin
                if (rst) cnt <= '0;
                else     cnt <= cnt + 1'b1;
            end
        end else begin : g_cmp
            always_ff @(posedge clk) begin
                if (rst)              cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end
        end
    endgenerate

    always_comb begin
        ev_o.fire = (cnt == LAST);
        ev_o.dir  = dir_i;
    end

endmodule

// File: rtl/imp_pend_track.sv
module imp_pend_track
    import imp_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int RESET_CODE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  eval_t             ev_i,
    output logic [CODE_W-1:0] pend_o
);
    localparam int MAX_CODE = (1 << CODE_W) - 1;

    logic [CODE_W-1:0] pend_nxt;

    always_comb begin
        pend_nxt = pend_o;
        if (ev_i.fire)
            pend_nxt = CODE_W'(step_sat(int'(pend_o), MAX_CODE, ev_i.dir));
    end

    always_ff @(posedge clk) begin
        if (rst) pend_o <= CODE_W'(RESET_CODE);
        else     pend_o <= pend_nxt;
    end

endmodule

// File: rtl/imp_pwrup_timer.sv
module imp_pwrup_timer #(
    parameter int PWRUP_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    output logic expired_o
);
    localparam int PW = $clog2(PWRUP_CYCLES + 1);
    localparam logic [PW-1:0] LIM = PW'(PWRUP_CYCLES);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign expired_o = (cnt == LIM);

endmodule

// File: rtl/imp_hiz_apply.sv
module imp_hiz_apply #(
    parameter int CODE_W     = 5,
    parameter int RESET_CODE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              out_hiz_i,
    input  logic [CODE_W-1:0] pend_i,
    input  logic              pu_expired_i,
    output logic [CODE_W-1:0] drv_o,
    output logic              cal_o
);
    logic hiz_q;
    logic entry;

    // Reset value 1: a bus already high-Z after reset is not a fresh entry.
    always_ff @(posedge clk) begin
        if (rst) hiz_q <= 1'b1;
        else     hiz_q <= out_hiz_i;
    end

    assign entry = out_hiz_i & ~hiz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_o <= CODE_W'(RESET_CODE);
            cal_o <= 1'b0;
        end else begin
            if (entry) drv_o <= pend_i;
            if (entry && pu_expired_i) cal_o <= 1'b1;
        end
    end

endmodule

// File: rtl/imp_step_ctrl.sv
module imp_step_ctrl
    import imp_pkg::*;
#(
    parameter int CODE_W       = 5,
    parameter int EVAL_CYCLES  = 64,
    parameter int PWRUP_CYCLES = 4096,
    parameter int RESET_CODE   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmp_dir,
    input  logic              out_hiz,
    output logic [CODE_W-1:0] drv_code,
    output logic              cal_done
);
    eval_t             ev;
    logic [CODE_W-1:0] pend_code;
    logic              pu_expired;

    imp_eval_timer #(.EVAL_CYCLES(EVAL_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .dir_i (dir_e'(cmp_dir)),
        .ev_o  (ev)
    );

    imp_pend_track #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .ev_i   (ev),
        .pend_o (pend_code)
    );

    imp_pwrup_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_pwr (
        .clk       (clk),
        .rst       (rst),
        .expired_o (pu_expired)
    );

    imp_hiz_apply #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_apply (
        .clk          (clk),
        .rst          (rst),
        .out_hiz_i    (out_hiz),
        .pend_i       (pend_code),
        .pu_expired_i (pu_expired),
        .drv_o        (drv_code),
        .cal_o        (cal_done)
    );

endmodule

// File: rtl/imp_step_ctrl_chk.sv
module imp_step_ctrl_chk #(
    parameter int CODE_W       = 5,
    parameter int EVAL_CYCLES  = 64,
    parameter int PWRUP_CYCLES = 4096
) (
    input logic              clk,
    input logic              rst,
    input logic              out_hiz,
    input logic [CODE_W-1:0] drv_code,
    input logic              cal_done,
    input logic [CODE_W-1:0] pend_code
);
    localparam int GW = $clog2(EVAL_CYCLES + 2) + 1;
    localparam int YW = $clog2(PWRUP_CYCLES + 2) + 1;

    logic [CODE_W-1:0] pend_q;
    logic [GW-1:0]     gap;
    logic [YW-1:0]     cyc;

    always_ff @(posedge clk) begin
        pend_q <= pend_code;
        if (rst) begin
            gap <= '0;
            cyc <= '0;
        end else begin
            if (pend_code != pend_q)       gap <= GW'(1);
            else if (gap < GW'(EVAL_CYCLES)) gap <= gap + 1'b1;
            if (cyc <= YW'(PWRUP_CYCLES))  cyc <= cyc + 1'b1;
        end
    end

    // R2: pending changes are spaced a full evaluation interval apart
    a_r2_eval_spacing: assert property (@(posedge clk) disable iff (rst)
        (pend_code != pend_q) |-> (gap >= GW'(EVAL_CYCLES)));

    // R3 and R4: pending moves by exactly one step and never wraps
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (pend_code != $past(pend_code)) |->
        ((32'(pend_code) == 32'($past(pend_code)) + 1) ||
         (32'(pend_code) + 1 == 32'($past(pend_code)))));

    // R5: applied code changes only one edge after a high-Z entry
    a_r5_change_on_entry: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && drv_code != $past(drv_code)) |->
        ($past(out_hiz) && !$past(out_hiz, 2)));

    // R5: an entry loads the pending value from before the edge
    a_r5_load_pending: assert property (@(posedge clk) disable iff (rst)
        (out_hiz && !$past(out_hiz) && !$past(rst)) |=> (drv_code == $past(pend_code)));

    // R8: flag is sticky
    a_r8_cal_sticky: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> cal_done);

    // R8: flag never before the power-up interval has elapsed
    a_r8_cal_late: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> (cyc > YW'(PWRUP_CYCLES)));

    // R8: flag rises only with an entry
    a_r8_cal_on_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_done) |-> $past(out_hiz));

endmodule

bind imp_step_ctrl imp_step_ctrl_chk #(
    .CODE_W       (CODE_W),
    .EVAL_CYCLES  (EVAL_CYCLES),
    .PWRUP_CYCLES (PWRUP_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_hiz   (out_hiz),
    .drv_code  (drv_code),
    .cal_done  (cal_done),
    .pend_code (pend_code)
);

// File: tb/tb_imp_step_ctrl.sv
`timescale 1ns/1ps
module tb_imp_step_ctrl;
    localparam int EVAL = 64;
    localparam int NV   = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cmp_dir = 2'b00;
    logic       out_hiz = 1'b0;
    logic [4:0] drv_code;
    logic       cal_done;

    int checks = 0;
    int fails  = 0;
    int ecnt   = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    imp_step_ctrl dut (
        .clk      (clk),
        .rst      (rst),
        .cmp_dir  (cmp_dir),
        .out_hiz  (out_hiz),
        .drv_code (drv_code),
        .cal_done (cal_done)
    );

    // Bench edge count since reset release.
    always @(posedge clk) begin
        if (rst) ecnt <= 0;
        else     ecnt <= ecnt + 1;
    end

    // {cmp_dir[1:0], apply, expected drv_code[4:0]}
    localparam logic [7:0] VEC [NV] = '{
        {2'b01, 1'b1, 5'd17},  // R3 raise, applied
        {2'b01, 1'b0, 5'd17},  // R5 not applied while driving
        {2'b01, 1'b1, 5'd19},  // R7 latest of two evaluations
        {2'b00, 1'b1, 5'd19},  // R3 hold 00
        {2'b10, 1'b1, 5'd18},  // R3 lower
        {2'b10, 1'b0, 5'd18},  // R7
        {2'b10, 1'b0, 5'd18},  // R7
        {2'b10, 1'b1, 5'd15},  // R7 three lowers applied at once
        {2'b01, 1'b1, 5'd16},  // R3
        {2'b11, 1'b1, 5'd16}   // R3 hold 11
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_eval();
        do begin
            @(posedge clk);
            #1;
        end while (ecnt % EVAL != 0);
    endtask

    task automatic window(input logic [1:0] d, input bit apply);
        @(negedge clk);
        cmp_dir = d;
        out_hiz = 1'b0;
        wait_eval();
        if (apply) begin
            @(negedge clk);
            out_hiz = 1'b1;
            @(negedge clk);
            out_hiz = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset drv", int'(drv_code), 16);
        chk("R1 reset cal", int'(cal_done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release drv", int'(drv_code), 16);

        for (int i = 0; i < NV; i++) begin
            window(VEC[i][7:6], VEC[i][5]);
            chk($sformatf("R3/R5/R7 vec%0d", i), int'(drv_code), int'(VEC[i][4:0]));
            chk("R8 no cal before 4096", int'(cal_done), 0);
        end

        // R4 upper saturation
        for (int i = 0; i < 20; i++) window(2'b01, 1'b0);
        window(2'b00, 1'b1);
        chk("R4 top saturation", int'(drv_code), 31);
        chk("R8 entry before 4096 no cal", int'(cal_done), 0);

        // R4 lower saturation, crossing the power-up point
        for (int i = 0; i < 40; i++) window(2'b10, 1'b0);
        chk("R8 no entry yet after 4096", int'(cal_done), 0);
        window(2'b00, 1'b1);
        chk("R4 bottom saturation", int'(drv_code), 0);
        chk("R8 cal at first entry", int'(cal_done), 1);

        // R6: stay high-Z across an evaluation
        @(negedge clk);
        cmp_dir = 2'b01;
        out_hiz = 1'b1;
        wait_eval();
        @(negedge clk);
        chk("R6 held high-Z no update", int'(drv_code), 0);
        out_hiz = 1'b0;
        @(negedge clk);
        out_hiz = 1'b1;
        @(negedge clk);
        chk("R6 re-entry applies", int'(drv_code), 1);
        chk("R8 cal sticky", int'(cal_done), 1);
        out_hiz = 1'b0;

        // R1 mid-run reset, then R2 exact evaluation edge
        @(negedge clk);
        rst = 1'b1;
        cmp_dir = 2'b01;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset drv", int'(drv_code), 16);
        chk("R1 mid reset cal", int'(cal_done), 0);
        while (ecnt != EVAL - 1) @(negedge clk);
        out_hiz = 1'b1;       // entry on the 64th edge
        @(negedge clk);
        chk("R2 entry on eval edge uses old pending", int'(drv_code), 16);
        out_hiz = 1'b0;
        @(negedge clk);
        out_hiz = 1'b1;
        @(negedge clk);
        chk("R2 first eval at edge 64", int'(drv_code), 17);
        out_hiz = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule